// File: doc/BRIEF.md
# Packed SIMD Integer Min/Max Unit

This unit accepts one 32-bit vector instruction word together with two packed operand vectors, called N and M. It decodes the word's fields and, for every lane, writes either the larger or the smaller of the two corresponding operand lanes. The instruction fields choose the operation at run time: maximum or minimum, signed or unsigned compare, a lane width of 8, 16 or 32 bits, and an operand length of 64 or 128 bits. The same instruction fields also give the five-bit destination register number, which the unit passes on decoded.

A caller presents the word and both operands with `valid_i`. One clock later the unit returns either a result with `res_valid_o`, or a rejection with `undef_o` when the word is not a legal encoding of this operation. The result, the destination index and the vector-length flag all come from the same single register stage. Reading the register file, checking access permissions and handling conditional execution are left to the logic around the unit.

Top module: `simd_minmax_unit`

## Requirements
- R1: With op (instr bit 4) = 0, each result lane equals the larger of the corresponding N and M lanes.
- R2: With op = 1, each result lane equals the smaller of the corresponding N and M lanes.
- R3: Instr bit 24 = 0 compares lanes as two's-complement signed values; bit 24 = 1 compares them as unsigned values.
- R4: Instr bits 21:20 select the lane width: 00 for 8 bits, 01 for 16 bits, 10 for 32 bits. Each result lane has the same width as the operand lanes.
- R5: Bits 21:20 = 11 raise `undef_o` and keep `res_valid_o` low. `res_valid_o` and `undef_o` are never high together.
- R6: Instr bit 6 = 1 selects 128-bit operands and bit 6 = 0 selects 64-bit operands. `quad_o` reports bit 6 of the accepted word.
- R7: With 64-bit operands, operand bits 127:64 have no effect, and `res_o[127:64]` is zero.
- R8: `dst_o` equals {instr bit 22, instr bits 15:12}.
- R9: With bit 6 = 1, an odd register number raises `undef_o`. The odd-number test looks at instr bit 12 (D:Vd), bit 16 (N:Vn) and bit 0 (M:Vm).
- R10: The word is legal only when bits 31:25 = 1111001 and bits 11:8 = 0110; any other value in those bits raises `undef_o`.
- R11: `res_valid_o` or `undef_o` is high exactly one clock after a cycle with `valid_i` high, and both are low one clock after a cycle with `valid_i` low.
- R12: Asserting `rst_ni` low clears `res_valid_o` and `undef_o`.
- R13: While `undef_o` is high, `res_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Word and operands are presented |
| instr_i | input | 32 | Instruction word |
| opn_i | input | 128 | First operand vector (N) |
| opm_i | input | 128 | Second operand vector (M) |
| res_valid_o | output | 1 | Legal word; result is valid |
| res_o | output | 128 | Lane-wise min/max result |
| dst_o | output | 5 | Decoded destination register number |
| quad_o | output | 1 | 1 for 128-bit operation, 0 for 64-bit |
| undef_o | output | 1 | Word was rejected as undefined |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector made of four 32-bit slices. With these values every lane width, both vector lengths and the gating of the upper half can be reached. Randomly filled words and operands test all twelve operation variants against a lane-by-lane model in the bench. Directed cases target sign-boundary lanes, reserved size codes, odd quad registers, corrupted fixed bits and reset in the middle of traffic.

// File: rtl/simd_mm_pkg.sv
package simd_mm_pkg;

  typedef enum logic [1:0] {
    LW_8   = 2'b00,
    LW_16  = 2'b01,
    LW_32  = 2'b10,
    LW_BAD = 2'b11
  } lane_w_e;

  typedef struct packed {
    logic      is_min;
    logic      is_uns;
    lane_w_e   lw;
    logic      quad;
    logic [4:0] dst;
    logic      illegal;
  } dec_s;

  localparam logic [6:0] FIX_HI  = 7'b1111001;
  localparam logic [3:0] FIX_MID = 4'b0110;

endpackage

// File: rtl/simd_mm_decode.sv
module simd_mm_decode
  import simd_mm_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_s        dec_o
);

  logic hi_bad, mid_bad, size_bad, odd_reg;
  logic unused_bit23;

  assign unused_bit23 = instr_i[23];

  always_comb begin
    hi_bad   = instr_i[31:25] != FIX_HI;
    mid_bad  = instr_i[11:8] != FIX_MID;
    size_bad = instr_i[21:20] == 2'b11;
    // quad registers must be even: D:Vd, N:Vn, M:Vm
    odd_reg  = instr_i[6] & (instr_i[12] | instr_i[16] | instr_i[0]);

    dec_o.is_min  = instr_i[4];
    dec_o.is_uns  = instr_i[24];
    dec_o.lw      = lane_w_e'(instr_i[21:20]);
    dec_o.quad    = instr_i[6];
    dec_o.dst     = {instr_i[22], instr_i[15:12]};
    dec_o.illegal = hi_bad | mid_bad | size_bad | odd_reg;
  end

endmodule

// File: rtl/simd_mm_cmp.sv
module simd_mm_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         uns_i,
  input  logic         min_i,
  output logic [W-1:0] res_o
);

  logic signed [W:0] ax, bx;
  logic              a_gt;

  always_comb begin
    // one extra bit: zero for unsigned, sign copy for signed
    ax    = {~uns_i & a_i[W-1], a_i};
    bx    = {~uns_i & b_i[W-1], b_i};
    a_gt  = ax > bx;
    res_o = (a_gt ^ min_i) ? a_i : b_i;
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, uns_i, min_i}))
      assert_pick_operand_R1: assert (res_o == a_i || res_o == b_i);
  end

endmodule

// File: rtl/simd_mm_slice.sv
module simd_mm_slice
  import simd_mm_pkg::*;
#(
  parameter int SLICE_W = 32
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  lane_w_e            lw_i,
  input  logic               uns_i,
  input  logic               min_i,
  output logic [SLICE_W-1:0] res_o
);

  localparam int N8  = SLICE_W / 8;
  localparam int N16 = SLICE_W / 16;
  localparam int N32 = SLICE_W / 32;

  logic [SLICE_W-1:0] r8, r16, r32;

  for (genvar g = 0; g < N8; g++) begin : g_l8
    simd_mm_cmp #(.W(8)) u_cmp (
      .a_i(a_i[g*8 +: 8]), .b_i(b_i[g*8 +: 8]),
      .uns_i(uns_i), .min_i(min_i), .res_o(r8[g*8 +: 8]));
  end

  for (genvar g = 0; g < N16; g++) begin : g_l16
    simd_mm_cmp #(.W(16)) u_cmp (
      .a_i(a_i[g*16 +: 16]), .b_i(b_i[g*16 +: 16]),
      .uns_i(uns_i), .min_i(min_i), .res_o(r16[g*16 +: 16]));
  end

  for (genvar g = 0; g < N32; g++) begin : g_l32
    simd_mm_cmp #(.W(32)) u_cmp (
      .a_i(a_i[g*32 +: 32]), .b_i(b_i[g*32 +: 32]),
      .uns_i(uns_i), .min_i(min_i), .res_o(r32[g*32 +: 32]));
  end

  always_comb begin
    unique case (lw_i)
      LW_8:    res_o = r8;
      LW_16:   res_o = r16;
      LW_32:   res_o = r32;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_minmax_unit.sv
module simd_minmax_unit
  import simd_mm_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int SLICE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [31:0]      instr_i,
  input  logic [VEC_W-1:0] opn_i,
  input  logic [VEC_W-1:0] opm_i,
  output logic             res_valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic [4:0]       dst_o,
  output logic             quad_o,
  output logic             undef_o
);

  localparam int HALF_W  = VEC_W / 2;
  localparam int N_SLICE = VEC_W / SLICE_W;

  dec_s             dec;
  logic [VEC_W-1:0] n_eff, m_eff, res_comb, res_d;

  simd_mm_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  // doubleword: upper half forced to zero so the result upper half is zero
  always_comb begin
    n_eff = dec.quad ? opn_i : {{HALF_W{1'b0}}, opn_i[HALF_W-1:0]};
    m_eff = dec.quad ? opm_i : {{HALF_W{1'b0}}, opm_i[HALF_W-1:0]};
  end

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    simd_mm_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a_i  (n_eff[s*SLICE_W +: SLICE_W]),
      .b_i  (m_eff[s*SLICE_W +: SLICE_W]),
      .lw_i (dec.lw),
      .uns_i(dec.is_uns),
      .min_i(dec.is_min),
      .res_o(res_comb[s*SLICE_W +: SLICE_W]));
  end

  assign res_d = dec.illegal ? '0 : res_comb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      undef_o     <= 1'b0;
      res_o       <= '0;
      dst_o       <= '0;
      quad_o      <= 1'b0;
    end else begin
      res_valid_o <= valid_i & ~dec.illegal;
      undef_o     <= valid_i & dec.illegal;
      if (valid_i) begin
        res_o  <= res_d;
        dst_o  <= dec.dst;
        quad_o <= dec.quad;
      end
    end
  end

  // checks
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ((res_valid_o | undef_o) == $past(valid_i)));

  assert_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && undef_o));

  assert_dword_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !quad_o) |-> (res_o[VEC_W-1:HALF_W] == '0));

  assert_undef_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (res_o == '0));

  assert_quad_even_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && quad_o) |-> !dst_o[0]);

endmodule

// File: tb/tb_simd_minmax_unit.sv
module tb_simd_minmax_unit;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [127:0] opn_i = '0, opm_i = '0;
  logic         res_valid_o, quad_o, undef_o;
  logic [127:0] res_o;
  logic [4:0]   dst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_minmax_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .opn_i(opn_i), .opm_i(opm_i), .res_valid_o(res_valid_o), .res_o(res_o),
    .dst_o(dst_o), .quad_o(quad_o), .undef_o(undef_o));

  function automatic logic [31:0] mk(input logic u, d, input logic [1:0] sz,
      input logic [3:0] vn, vd, input logic n, q, m, op, input logic [3:0] vm);
    return {7'b1111001, u, 1'b0, d, sz, vn, vd, 4'b0110, n, q, m, op, vm};
  endfunction

  function automatic void model(input logic [31:0] ins, input logic [127:0] n, m,
                                output logic und, output logic [127:0] r);
    int w, len;
    logic [63:0] mask;
    logic [31:0] a, b, sb, pick;
    logic agt;
    und = (ins[31:25] != 7'b1111001) || (ins[11:8] != 4'b0110) ||
          (ins[21:20] == 2'b11) || (ins[6] && (ins[12] || ins[16] || ins[0]));
    r = '0;
    if (und) return;
    w    = 8 << ins[21:20];
    len  = ins[6] ? 128 : 64;
    mask = (64'd1 << w) - 64'd1;
    sb   = ins[24] ? 32'd0 : 32'(64'd1 << (w - 1));
    for (int p = 0; p < len; p += w) begin
      a    = 32'((n >> p) & {64'd0, mask});
      b    = 32'((m >> p) & {64'd0, mask});
      agt  = (a ^ sb) > (b ^ sb);
      pick = ins[4] ? (agt ? b : a) : (agt ? a : b);
      r    = r | ({96'd0, pick} << p);
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [127:0] n, m, input string tag);
    logic und;
    logic [127:0] r;
    model(ins, n, m, und, r);
    @(negedge clk);
    valid_i = 1'b1; instr_i = ins; opn_i = n; opm_i = m;
    @(negedge clk);
    valid_i = 1'b0;
    chk(undef_o == und, {tag, " undef"}, 128'(undef_o), 128'(und));
    chk(res_valid_o == !und, {tag, " R11 res_valid"}, 128'(res_valid_o), 128'(!und));
    chk(res_o == r, {tag, " result"}, res_o, r);
    if (!und) begin
      chk(dst_o == {ins[22], ins[15:12]}, "R8 dst", 128'(dst_o), 128'({ins[22], ins[15:12]}));
      chk(quad_o == ins[6], "R6 quad", 128'(quad_o), 128'(ins[6]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ins;
    logic [127:0] n, m;
    string tag;
    void'($urandom(32'd20240611));

    // R12: reset state
    #(CLK_PERIOD * 2 + 1);
    chk(res_valid_o == 0 && undef_o == 0, "R12 reset", {res_valid_o, undef_o}, 0);
    @(negedge clk); rst_ni = 1'b1;

    // R1 / R2: signed 8-bit quad, mixed signs
    n = 128'h80_7F_01_FF_00_10_F0_0F_22_DD_44_BB_66_99_7E_81;
    m = 128'h7F_80_FF_01_10_00_0F_F0_DD_22_BB_44_99_66_81_7E;
    run(mk(0, 0, 2'b00, 4'h2, 4'h4, 0, 1, 0, 0, 4'h6), n, m, "R1 s8 max");
    run(mk(0, 0, 2'b00, 4'h2, 4'h4, 0, 1, 0, 1, 4'h6), n, m, "R2 s8 min");
    // R3: unsigned vs signed on the sign boundary
    run(mk(1, 0, 2'b00, 4'h2, 4'h4, 0, 1, 0, 0, 4'h6), n, m, "R3 u8 max");
    run(mk(1, 0, 2'b00, 4'h2, 4'h4, 0, 1, 0, 1, 4'h6), n, m, "R3 u8 min");
    // R4: wider lanes
    run(mk(0, 0, 2'b01, 4'h0, 4'h2, 0, 1, 0, 0, 4'h4), n, m, "R4 s16 max");
    run(mk(1, 0, 2'b10, 4'h0, 4'h2, 0, 1, 0, 1, 4'h4), n, m, "R4 u32 min");
    run(mk(0, 1, 2'b10, 4'h0, 4'h2, 0, 1, 0, 0, 4'h4),
        {4{32'h8000_0000}}, {4{32'h7FFF_FFFF}}, "R4 s32 max");
    // R5: reserved size
    run(mk(0, 0, 2'b11, 4'h0, 4'h2, 0, 1, 0, 0, 4'h4), n, m, "R5 size11");
    // R6 / R7: doubleword, upper operand garbage
    run(mk(0, 1, 2'b00, 4'h3, 4'h7, 1, 0, 1, 0, 4'h9),
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF},
        {64'h7777_7777_7777_7777, 64'hFEDC_BA98_7654_3210}, "R7 dword");
    // R8: destination bits
    run(mk(1, 1, 2'b01, 4'h0, 4'hA, 0, 1, 0, 0, 4'h0), n, m, "R8 dst");
    // R9: odd registers in quad mode only
    run(mk(0, 0, 2'b00, 4'h1, 4'h2, 0, 1, 0, 0, 4'h4), n, m, "R9 odd vn");
    run(mk(0, 0, 2'b00, 4'h2, 4'h3, 0, 1, 0, 0, 4'h4), n, m, "R9 odd vd");
    run(mk(0, 0, 2'b00, 4'h2, 4'h2, 0, 1, 0, 0, 4'h5), n, m, "R9 odd vm");
    run(mk(0, 0, 2'b00, 4'h1, 4'h3, 0, 0, 0, 0, 4'h5), n, m, "R9 odd dword ok");
    // R10: fixed bits
    run(mk(0, 0, 2'b00, 4'h2, 4'h2, 0, 1, 0, 0, 4'h4) ^ 32'h0000_0200, n, m, "R10 bit9");
    run(mk(0, 0, 2'b00, 4'h2, 4'h2, 0, 1, 0, 0, 4'h4) ^ 32'h1000_0000, n, m, "R10 bit28");

    // R11: idle cycle
    @(negedge clk);
    chk(res_valid_o == 0 && undef_o == 0, "R11 idle", {res_valid_o, undef_o}, 0);

    // R12: reset mid-traffic
    @(negedge clk);
    valid_i = 1'b1; instr_i = mk(0, 0, 2'b00, 4'h2, 4'h4, 0, 1, 0, 0, 4'h6);
    @(negedge clk);
    valid_i = 1'b0; rst_ni = 1'b0;
    #1;
    chk(res_valid_o == 0 && undef_o == 0, "R12 async reset", {res_valid_o, undef_o}, 0);
    @(negedge clk); rst_ni = 1'b1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [1:0] sz;
      logic q;
      sel = int'($urandom % 16);
      sz  = 2'($urandom % 3);
      if (sel == 1) sz = 2'b11;
      q   = 1'($urandom);
      ins = mk(1'($urandom), 1'($urandom), sz, 4'($urandom), 4'($urandom),
               1'($urandom), q, 1'($urandom), 1'($urandom), 4'($urandom));
      if (q && sel != 2) begin
        ins[12] = 1'b0; ins[16] = 1'b0; ins[0] = 1'b0;
      end
      if (sel == 0) ins = ins ^ (32'd1 << (($urandom % 2) ? 25 + $urandom % 7 : 8 + $urandom % 4));
      n = {$urandom, $urandom, $urandom, $urandom};
      m = {$urandom, $urandom, $urandom, $urandom};
      if (sel == 3) m = n;
      if (ins[31:25] != 7'b1111001 || ins[11:8] != 4'b0110) tag = "R10 rnd";
      else if (ins[21:20] == 2'b11) tag = "R5 rnd";
      else if (ins[6] && (ins[12] || ins[16] || ins[0])) tag = "R9 rnd";
      else if (!ins[6]) tag = "R7 rnd";
      else tag = ins[4] ? "R2 rnd" : "R1 rnd";
      run(ins, n, m, tag);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule